// File: doc/BRIEF.md
# Real-Time Clock Shadow Access Controller

This block holds a free-running time-of-day counter (sub-second ticks, seconds, minutes, hours) and controls how software reaches it through a small register bus. Software never touches the live counters directly. A set of shadow registers sits between the bus and the counters. A two-bit control register carries a snapshot request and a write-window enable.

Setting the snapshot bit copies the running time into the shadows and holds it there, so a multi-field value can be read without tearing while the clock keeps counting. Setting the window bit lets software stage new seconds, minutes and hours values. Clearing it commits the staged fields to the counters. A field that was not written during the window is left alone and keeps counting. A status register shows a busy flag for a short, fixed time after each commit.

The counters use their own reset, `rtc_rst_n`. The control logic and the shadows use `rst_n`. Because of this, a control reset throws away an open window without disturbing the time.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: Register map by `bus_addr`:
  - 0 is control: bit 0 = READ, bit 1 = WRITE, other bits read 0.
  - 1 is status: bit 0 = BUSY.
  - 2, 3 and 4 are the seconds, minutes and hours shadows.
  - 5 is the tick shadow, which is read-only.
  - 6 and 7 read 0.
  - After reset, control and status read 0.
- R2: A write to control that sets READ copies the live ticks, seconds, minutes and hours into the shadows at that clock edge. While READ stays 1 the shadows hold their value and the live counters keep running.
- R3: Writes to addresses 2 to 4 while WRITE is 0 leave the shadows unchanged.
- R4: A control write that changes WRITE from 1 to 0 commits the staged shadows into the live counters at that edge.
- R5: A commit loads only the fields whose shadows were written during the window. Every other field keeps counting normally.
- R6: A commit that loads seconds also sets the tick counter to 0 at the same edge. A tick in that cycle is discarded.
- R7: A control write that tries to set WRITE is refused in three cases: when BUSY is 1, when READ is 1, or when the same write has bit 0 set. READ and WRITE are never 1 together.
- R8: If `rst_n` is asserted while WRITE is 1, the staged values are discarded. No commit happens and the live time keeps running.
- R9: BUSY reads 1 for exactly COMMIT_CYCLES (default 2) cycles after the commit edge, then reads 0.
- R10: A control write that tries to set READ is refused while WRITE is 1 or while BUSY is 1.
- R11: The counters wrap as follows:
  - Ticks wrap at TICKS_PER_SEC − 1 and carry into seconds.
  - Seconds and minutes wrap at 59 and carry into the next field.
  - Hours wrap at 23.
- R12: Setting WRITE clears the record of written fields, as does a commit. A field committed in one window is therefore not loaded again by a later window that did not write it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low async reset for control, status, shadows and the written-field flags |
| rtc_rst_n | input | 1 | Active-low async reset for the live time counters |
| tick | input | 1 | Sub-second tick strobe that advances the live time |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Commits are tried in several forms:
- All three fields written together, which shows the seconds-driven tick clear apart from ordinary counting.
- Only one field written, which shows selective loading apart from a blanket copy.
- Two successive windows, which tell stale written-field flags apart from cleared ones.

Control writes cover every combination of the two bits against the current READ, WRITE and BUSY state. This separates each refusal rule from the others.

Further directed cases cover:
- ticks run across the 23:59:59 rollover;
- a control reset taken with a window open;
- stage writes made with the window closed.

Constrained-random bus traffic, interleaved with ticks, then compares every read against an independent model.

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl #(
  parameter int TICKS_PER_SEC = 32,
  parameter int COMMIT_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rtc_rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int TW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int BW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_SEC - 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_SEC = 3'd2,
                         A_MIN = 3'd3, A_HOUR = 3'd4, A_TICK = 3'd5;

  logic          rd_q, wr_q;
  logic [BW-1:0] busy_cnt;
  logic [2:0]    dirty;
  logic [5:0]    sh_sec, sh_min;
  logic [4:0]    sh_hour;
  logic [TW-1:0] sh_tick;
  logic [TW-1:0] tk;
  logic [5:0]    sec, mn;
  logic [4:0]    hr;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[31:6];

  wire busy    = busy_cnt != '0;
  wire ctrl_wr = bus_wr && bus_addr == A_CTRL;
  wire set_rd  = ctrl_wr && bus_wdata[0] && !rd_q && !wr_q && !busy;
  wire set_wr  = ctrl_wr && bus_wdata[1] && !wr_q && !rd_q && !busy && !bus_wdata[0];
  wire commit  = ctrl_wr && wr_q && !bus_wdata[1];
  wire stg_wr  = bus_wr && wr_q && (bus_addr == A_SEC || bus_addr == A_MIN || bus_addr == A_HOUR);

  wire sec_load = commit && dirty[0];
  wire tk_wrap  = tick && tk == TICK_LAST && !sec_load;
  wire sec_wrap = tk_wrap && sec == 6'd59;
  wire min_wrap = sec_wrap && mn == 6'd59;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      busy_cnt <= '0;
      dirty    <= '0;
      sh_sec   <= '0;
      sh_min   <= '0;
      sh_hour  <= '0;
      sh_tick  <= '0;
    end else begin
      if (ctrl_wr) begin
        rd_q <= rd_q ? bus_wdata[0] : set_rd;
        wr_q <= wr_q ? bus_wdata[1] : set_wr;
      end
      if (commit)    busy_cnt <= BW'(COMMIT_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (commit || set_wr) dirty <= '0;
      else if (stg_wr)      dirty[bus_addr - A_SEC] <= 1'b1;
      if (set_rd) begin
        sh_sec  <= sec;
        sh_min  <= mn;
        sh_hour <= hr;
        sh_tick <= tk;
      end else if (stg_wr) begin
        case (bus_addr)
          A_SEC:   sh_sec  <= bus_wdata[5:0];
          A_MIN:   sh_min  <= bus_wdata[5:0];
          default: sh_hour <= bus_wdata[4:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      tk  <= '0;
      sec <= '0;
      mn  <= '0;
      hr  <= '0;
    end else begin
      if (sec_load)  tk <= '0;
      else if (tick) tk <= (tk == TICK_LAST) ? '0 : tk + 1'b1;

      if (sec_load)     sec <= sh_sec;
      else if (tk_wrap) sec <= (sec == 6'd59) ? 6'd0 : sec + 6'd1;

      if (commit && dirty[1]) mn <= sh_min;
      else if (sec_wrap)      mn <= (mn == 6'd59) ? 6'd0 : mn + 6'd1;

      if (commit && dirty[2]) hr <= sh_hour;
      else if (min_wrap)      hr <= (hr == 5'd23) ? 5'd0 : hr + 5'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {30'd0, wr_q, rd_q};
      A_STAT:  bus_rdata = {31'd0, busy};
      A_SEC:   bus_rdata = {26'd0, sh_sec};
      A_MIN:   bus_rdata = {26'd0, sh_min};
      A_HOUR:  bus_rdata = {27'd0, sh_hour};
      A_TICK:  bus_rdata = 32'(sh_tick);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_shadow_ctrl_chk.sv
module rtc_shadow_ctrl_chk #(
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rtc_rst_n,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [1:0]    wd,
  input logic          rd_q,
  input logic          wr_q,
  input logic          busy,
  input logic          dsec,
  input logic [5:0]    sh_sec,
  input logic [5:0]    sh_min,
  input logic [4:0]    sh_hour,
  input logic [TW-1:0] sh_tick,
  input logic [TW-1:0] tk,
  input logic [5:0]    sec,
  input logic [5:0]    mn,
  input logic [4:0]    hr
);
  wire cw = bus_wr && bus_addr == 3'd0;

  AST_TIME_RANGE: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    sec <= 6'd59 && mn <= 6'd59 && hr <= 5'd23); // R11

  AST_STAGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    bus_wr && !wr_q && bus_addr >= 3'd2 && bus_addr <= 3'd4
    |=> $stable(sh_sec) && $stable(sh_min) && $stable(sh_hour)); // R3

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    rd_q && !cw |=> $stable(sh_sec) && $stable(sh_min) && $stable(sh_hour) && $stable(sh_tick)); // R2

  AST_SEC_CLEARS_TICKS: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    cw && wr_q && !wd[1] && dsec |=> tk == '0 && sec == $past(sh_sec)); // R6

  AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    cw && wd[1] && !wr_q && (busy || rd_q || wd[0]) |=> !wr_q); // R7

  AST_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    cw && wd[0] && !rd_q && (wr_q || busy) |=> !rd_q); // R10

  AST_BUSY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    cw && wr_q && !wd[1] |=> busy); // R9

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
    !(rd_q && wr_q)); // R7
endmodule

bind rtc_shadow_ctrl rtc_shadow_ctrl_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wd(bus_wdata[1:0]), .rd_q(rd_q), .wr_q(wr_q),
  .busy(busy), .dsec(dirty[0]), .sh_sec(sh_sec), .sh_min(sh_min),
  .sh_hour(sh_hour), .sh_tick(sh_tick), .tk(tk), .sec(sec), .mn(mn), .hr(hr)
);

// File: tb/rtc_shadow_ctrl_test.sv
`timescale 1ns/1ps
module rtc_shadow_ctrl_test;
  localparam int TPS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, rtc_rst_n = 1'b0;
  logic        tick = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #2.5 clk = ~clk;

  rtc_shadow_ctrl #(.TICKS_PER_SEC(TPS), .COMMIT_CYCLES(2)) uut (
    .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n), .tick(tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_tk, m_s, m_m, m_h;
  int m_rd, m_wr, m_busy;
  int sh_s, sh_m, sh_h, sh_t;
  bit [2:0] dty;

  function automatic int exp_rd(int a);
    case (a)
      0: return (m_wr << 1) | m_rd;
      1: return (m_busy > 0) ? 1 : 0;
      2: return sh_s;
      3: return sh_m;
      4: return sh_h;
      5: return sh_t;
      default: return 0;
    endcase
  endfunction

  task automatic advance();
    m_tk++;
    if (m_tk == TPS) begin
      m_tk = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_m++;
        if (m_m == 60) begin
          m_m = 0; m_h = (m_h == 23) ? 0 : m_h + 1;
        end
      end
    end
  endtask

  task automatic model_edge(bit w, int a, int d, bit t);
    bit busy   = m_busy > 0;
    bit cw     = w && a == 0;
    bit commit = cw && m_wr != 0 && !d[1];
    bit set_rd = cw && d[0] && m_rd == 0 && m_wr == 0 && !busy;
    bit set_wr = cw && d[1] && m_wr == 0 && m_rd == 0 && !busy && !d[0];
    bit stg    = w && m_wr != 0 && a >= 2 && a <= 4;
    int o_tk = m_tk, o_s = m_s, o_m = m_m, o_h = m_h;
    if (commit && dty[0]) begin m_tk = 0; m_s = sh_s; end
    else if (t) advance();
    if (commit && dty[1]) m_m = sh_m;
    if (commit && dty[2]) m_h = sh_h;
    if (set_rd) begin sh_s = o_s; sh_m = o_m; sh_h = o_h; sh_t = o_tk; end
    else if (stg) begin
      if (a == 2) sh_s = d & 63;
      else if (a == 3) sh_m = d & 63;
      else sh_h = d & 31;
    end
    if (commit || set_wr) dty = '0;
    else if (stg) dty[a-2] = 1'b1;
    if (cw) begin
      m_rd = (m_rd != 0) ? int'(d[0]) : int'(set_rd);
      m_wr = (m_wr != 0) ? int'(d[1]) : int'(set_wr);
    end
    m_busy = commit ? 2 : (busy ? m_busy - 1 : 0);
  endtask

  task automatic step(bit w, int a, int d, bit t, string tag);
    @(negedge clk);
    bus_wr = w; bus_addr = a[2:0]; bus_wdata = d; tick = t;
    #1;
    n_chk++;
    if (bus_rdata !== 32'(exp_rd(a))) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, bus_rdata, exp_rd(a));
    end
    @(posedge clk);
    model_edge(w, a, d, t);
  endtask

  task automatic ctl_rst();
    @(negedge clk);
    bus_wr = 0; tick = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    m_rd = 0; m_wr = 0; m_busy = 0; dty = '0;
    sh_s = 0; sh_m = 0; sh_h = 0; sh_t = 0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd42));
    m_tk = 0; m_s = 0; m_m = 0; m_h = 0;
    m_rd = 0; m_wr = 0; m_busy = 0; dty = '0;
    sh_s = 0; sh_m = 0; sh_h = 0; sh_t = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; rtc_rst_n = 1;

    step(0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");
    step(0, 6, 0, 0, "R1");
    for (int i = 0; i < 21; i++) step(0, 5, 0, 1, "R2");
    step(1, 0, 1, 0, "R2");
    step(0, 5, 0, 1, "R2");
    for (int i = 0; i < 12; i++) step(0, 2 + i % 4, 0, 1, "R2");
    step(1, 0, 0, 0, "R2");
    step(1, 2, 30, 0, "R3");
    step(1, 4, 9, 0, "R3");
    step(0, 2, 0, 0, "R3");
    step(0, 4, 0, 0, "R3");

    step(1, 0, 2, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 3, 0, "R10");
    step(0, 0, 0, 0, "R10");
    step(1, 2, 58, 0, "R4");
    step(1, 3, 59, 0, "R4");
    step(1, 4, 23, 0, "R4");
    step(1, 0, 0, 1, "R6");
    step(1, 0, 2, 0, "R9");
    step(1, 0, 1, 0, "R10");
    step(0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 1, 0, "R6");
    step(0, 5, 0, 0, "R6");
    step(0, 2, 0, 0, "R4");
    step(0, 3, 0, 0, "R4");
    step(0, 4, 0, 0, "R4");
    step(1, 0, 3, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, "R7");
    step(1, 0, 3, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, "R11");
    for (int i = 0; i < 2 * TPS; i++) step(0, 1, 0, 1, "R11");
    step(1, 0, 1, 0, "R11");
    step(0, 2, 0, 0, "R11");
    step(0, 3, 0, 0, "R11");
    step(0, 4, 0, 0, "R11");
    step(1, 0, 0, 0, "R11");

    step(1, 0, 2, 0, "R12");
    step(1, 2, 10, 0, "R12");
    step(1, 0, 0, 0, "R12");
    for (int i = 0; i < TPS + 3; i++) step(0, 1, 0, 1, "R12");
    step(1, 0, 2, 0, "R5");
    step(1, 4, 5, 0, "R5");
    step(1, 0, 0, 1, "R5");
    step(0, 1, 0, 1, "R9");
    step(0, 1, 0, 1, "R9");
    step(1, 0, 1, 0, "R12");
    step(0, 2, 0, 0, "R12");
    step(0, 4, 0, 0, "R5");
    step(0, 5, 0, 0, "R5");
    step(1, 0, 0, 0, "R5");

    step(1, 0, 2, 0, "R8");
    step(1, 2, 40, 1, "R8");
    ctl_rst();
    step(0, 0, 0, 1, "R8");
    step(1, 0, 1, 0, "R8");
    step(0, 2, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit t = 1'($urandom_range(0, 1));
      if (r < 10) step(1, 0, $urandom_range(0, 3), t, "R1");
      else if (r < 28) begin
        int a = $urandom_range(2, 4);
        step(1, a, (a == 4) ? $urandom_range(0, 23) : $urandom_range(0, 59), t, "R3");
      end else if (r < 29) ctl_rst();
      else step(0, $urandom_range(0, 7), 0, t, "R2");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule